// File: doc/BRIEF.md
# Reseeding Logic Self-Test Controller

This block runs a built-in logic self-test on a scan-based core. A 16-bit pseudo-random generator provides the stimulus, one bit per scan chain in each shift cycle, so that a set of short chains loads in parallel. After each capture cycle the chains are unloaded while the next pattern shifts in. The unloaded bits from all chains are folded into one multiple-input signature register. The generator is not left to run from a single starting state. After a fixed number of patterns it is reloaded from a small internal seed table, and each seed starts a new pattern segment.

A test is started with a one-cycle `start` pulse. The controller sequences shift, capture, compaction, seed reloading and a final unload on its own. It then raises `done`. At that point `signature` holds the compacted response, and `pass` reports whether it matches the golden value presented on `goldenSig`. The seed table is filled from parameters. A zero entry marks the end of the table and is never loaded.

Top module: `reseed_lbist`

## Requirements
- R1: After reset `done`, `pass` and `scanEn` are low and `signature` is zero.
- R2: In every shift cycle, scan chain c receives bit c of the 16-bit generator state on `scanIn[c]`. The generator then shifts one place toward the most significant bit, and the XOR of its bits 15, 13, 12 and 10 enters bit 0. Seed entry i equals (SEED_BASE + i·SEED_STEP) mod 2^16 with bit 0 forced to one for i < ACTIVE_SEEDS, and is zero otherwise. The first shift cycle after `start` presents seed 0.
- R3: Each pattern is CHAIN_LEN consecutive cycles with `scanEn` high, followed by exactly one capture cycle with `scanEn` low.
- R4: Each seed drives PATS_PER_SEED patterns. The next seed is loaded during the capture cycle of the last of these patterns, so the next shift cycle begins the new segment.
- R5: The run ends at the first zero table entry, or after TABLE_DEPTH seeds if none is zero. A zero entry is never loaded, so a run has min(ACTIVE_SEEDS, TABLE_DEPTH)·PATS_PER_SEED capture cycles.
- R6: After the last capture come CHAIN_LEN unload cycles with `scanEn` high and every `scanIn` bit zero. `done` rises in the next cycle.
- R7: `start` clears the signature register. In every cycle with `scanEn` high that follows the first capture of the run, the signature becomes its value shifted toward the MSB, with the XOR of its bits 15, 13, 12 and 10 in bit 0, XORed with `scanOut` placed on bits NUM_CHAINS-1..0. Before the first capture it holds zero.
- R8: `pass` is high exactly when `done` is high and `signature` equals `goldenSig`.
- R9: A `start` pulse that arrives while a run is in progress has no effect on the sequence, its length or the final signature.
- R10: `done` stays high and `signature` stays unchanged until the next `start`, which begins a fresh run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a test run |
| goldenSig | input | 16 | Expected final signature |
| scanOut | input | NUM_CHAINS | Serial outputs of the scan chains |
| scanEn | output | 1 | High to shift the chains, low to capture |
| scanIn | output | NUM_CHAINS | Serial stimulus into the scan chains |
| done | output | 1 | Run finished; held until next start |
| pass | output | 1 | Signature matches golden value (with done) |
| signature | output | 16 | Current signature register contents |

## Verification
The main instance uses four chains of eight bits, five patterns per seed, and a four-entry table with three live seeds, so the zero end marker is what ends its runs. A second instance uses two live seeds in a two-entry table and three patterns per seed, which brings the exhaustion path and a different segment length within reach. The bench drives both instances through a stand-in core with a nonlinear capture function. Against it, a model built from the requirements predicts the signature, the shift and capture counts, the unload phase and the first stimulus slice. Random golden values and random `start` pulses during a run cover the mismatch and ignore cases.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_CAPTURE,
    ST_FLUSH,
    ST_DONE
  } bistState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearMisr;
    logic loadSeed;
    logic stepLfsr;
    logic compact;
    logic zeroIn;
  } dpStrobe_t;

endpackage

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import lbist_pkg::*;
#(
  parameter int CHAIN_LEN     = 8,
  parameter int PATS_PER_SEED = 5,
  parameter int IDX_W         = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             seedZero,
  output dpStrobe_t        strobe,
  output logic [IDX_W-1:0] seedSel,
  output logic             scanEn,
  output logic             done
);

  localparam int BIT_W = $clog2(CHAIN_LEN + 1);
  localparam int PAT_W = $clog2(PATS_PER_SEED + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CHAIN_LEN - 1);
  localparam logic [PAT_W-1:0] LAST_PAT = PAT_W'(PATS_PER_SEED - 1);

  bistState_t       state;
  logic [BIT_W-1:0] bitCnt;
  logic [PAT_W-1:0] patCnt;
  logic [IDX_W-1:0] seedIdx;
  logic             seenCapture;

  always_comb begin
    strobe  = '0;
    seedSel = '0;
    scanEn  = 1'b0;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          strobe.clearMisr = 1'b1;
          strobe.loadSeed  = !seedZero;
        end
      end
      ST_SHIFT: begin
        scanEn          = 1'b1;
        strobe.stepLfsr = 1'b1;
        strobe.compact  = seenCapture;
      end
      ST_CAPTURE: begin
        if (patCnt == LAST_PAT) begin
          seedSel         = seedIdx + IDX_W'(1);
          strobe.loadSeed = !seedZero;
        end
      end
      ST_FLUSH: begin
        scanEn         = 1'b1;
        strobe.compact = 1'b1;
        strobe.zeroIn  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      bitCnt      <= '0;
      patCnt      <= '0;
      seedIdx     <= '0;
      seenCapture <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state       <= seedZero ? ST_DONE : ST_SHIFT;
            bitCnt      <= '0;
            patCnt      <= '0;
            seedIdx     <= '0;
            seenCapture <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (bitCnt == LAST_BIT) begin
            bitCnt <= '0;
            state  <= ST_CAPTURE;
          end else begin
            bitCnt <= bitCnt + BIT_W'(1);
          end
        end
        ST_CAPTURE: begin
          seenCapture <= 1'b1;
          if (patCnt == LAST_PAT) begin
            patCnt <= '0;
            if (seedZero) begin
              state <= ST_FLUSH;
            end else begin
              seedIdx <= seedSel;
              state   <= ST_SHIFT;
            end
          end else begin
            patCnt <= patCnt + PAT_W'(1);
            state  <= ST_SHIFT;
          end
        end
        ST_FLUSH: begin
          if (bitCnt == LAST_BIT) begin
            bitCnt <= '0;
            state  <= ST_DONE;
          end else begin
            bitCnt <= bitCnt + BIT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done = (state == ST_DONE);

endmodule

// File: rtl/lbist_datapath.sv
module lbist_datapath
  import lbist_pkg::*;
#(
  parameter int                NUM_CHAINS   = 4,
  parameter int                LFSR_W       = 16,
  parameter logic [LFSR_W-1:0] TAPS         = 16'hB400,
  parameter int                TABLE_DEPTH  = 4,
  parameter int                ACTIVE_SEEDS = 3,
  parameter logic [LFSR_W-1:0] SEED_BASE    = 16'hACE1,
  parameter logic [LFSR_W-1:0] SEED_STEP    = 16'h3D1B,
  parameter int                IDX_W        = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic [IDX_W-1:0]      seedSel,
  input  logic                  done,
  input  logic [NUM_CHAINS-1:0] scanOut,
  input  logic [LFSR_W-1:0]     goldenSig,
  output logic [NUM_CHAINS-1:0] scanIn,
  output logic                  seedZero,
  output logic [LFSR_W-1:0]     signature,
  output logic                  pass
);

  logic [LFSR_W-1:0] seedRom [TABLE_DEPTH];
  logic [LFSR_W-1:0] seedVal;
  logic [LFSR_W-1:0] lfsr;
  logic [LFSR_W-1:0] misr;

  // seed table computed from parameters; zero past the live entries
  for (genvar g = 0; g < TABLE_DEPTH; g++) begin : gSeed
    if (g < ACTIVE_SEEDS) begin : gLive
      assign seedRom[g] = LFSR_W'(SEED_BASE + LFSR_W'(g) * SEED_STEP) | LFSR_W'(1);
    end else begin : gEnd
      assign seedRom[g] = '0;
    end
  end

  // selections beyond the table read as zero (end of table)
  always_comb begin
    seedVal = '0;
    for (int i = 0; i < TABLE_DEPTH; i++) begin
      if (seedSel == IDX_W'(i)) seedVal = seedRom[i];
    end
  end

  assign seedZero = (seedVal == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr <= '0;
    end else if (strobe.loadSeed) begin
      lfsr <= seedVal;
    end else if (strobe.stepLfsr) begin
      lfsr <= {lfsr[LFSR_W-2:0], ^(lfsr & TAPS)};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      misr <= '0;
    end else if (strobe.clearMisr) begin
      misr <= '0;
    end else if (strobe.compact) begin
      misr <= {misr[LFSR_W-2:0], ^(misr & TAPS)} ^ LFSR_W'(scanOut);
    end
  end

  assign scanIn    = strobe.zeroIn ? '0 : lfsr[NUM_CHAINS-1:0];
  assign signature = misr;
  assign pass      = done && (misr == goldenSig);

endmodule

// File: rtl/reseed_lbist.sv
module reseed_lbist
  import lbist_pkg::*;
#(
  parameter int                NUM_CHAINS    = 4,
  parameter int                CHAIN_LEN     = 8,
  parameter int                PATS_PER_SEED = 5,
  parameter int                TABLE_DEPTH   = 4,
  parameter int                ACTIVE_SEEDS  = 3,
  parameter int                LFSR_W        = 16,
  parameter logic [LFSR_W-1:0] TAPS          = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED_BASE     = 16'hACE1,
  parameter logic [LFSR_W-1:0] SEED_STEP     = 16'h3D1B
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [LFSR_W-1:0]     goldenSig,
  input  logic [NUM_CHAINS-1:0] scanOut,
  output logic                  scanEn,
  output logic [NUM_CHAINS-1:0] scanIn,
  output logic                  done,
  output logic                  pass,
  output logic [LFSR_W-1:0]     signature
);

  localparam int IDX_W = $clog2(TABLE_DEPTH + 1);

  dpStrobe_t        strobe;
  logic [IDX_W-1:0] seedSel;
  logic             seedZero;

  lbist_ctrl #(
    .CHAIN_LEN    (CHAIN_LEN),
    .PATS_PER_SEED(PATS_PER_SEED),
    .IDX_W        (IDX_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .seedZero(seedZero),
    .strobe  (strobe),
    .seedSel (seedSel),
    .scanEn  (scanEn),
    .done    (done)
  );

  lbist_datapath #(
    .NUM_CHAINS  (NUM_CHAINS),
    .LFSR_W      (LFSR_W),
    .TAPS        (TAPS),
    .TABLE_DEPTH (TABLE_DEPTH),
    .ACTIVE_SEEDS(ACTIVE_SEEDS),
    .SEED_BASE   (SEED_BASE),
    .SEED_STEP   (SEED_STEP),
    .IDX_W       (IDX_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .seedSel  (seedSel),
    .done     (done),
    .scanOut  (scanOut),
    .goldenSig(goldenSig),
    .scanIn   (scanIn),
    .seedZero (seedZero),
    .signature(signature),
    .pass     (pass)
  );

endmodule

// File: rtl/lbist_chk.sv
module lbist_chk #(
  parameter int LFSR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              scanEn,
  input logic              done,
  input logic              pass,
  input logic [LFSR_W-1:0] signature,
  input logic [LFSR_W-1:0] goldenSig
);

  // R8
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> (done && signature == goldenSig));

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(signature)));

  // R3
  capture_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(scanEn) && !done) |=> scanEn);

  // R6
  done_no_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !scanEn);

  // R7
  misr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(done) |-> (signature == '0));

endmodule

bind reseed_lbist lbist_chk #(.LFSR_W(LFSR_W)) u_lbistChk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .scanEn   (scanEn),
  .done     (done),
  .pass     (pass),
  .signature(signature),
  .goldenSig(goldenSig)
);

// File: tb/cut_stub.sv
module cut_stub #(
  parameter int N = 4,
  parameter int L = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         scanEn,
  input  logic [N-1:0] scanIn,
  output logic [N-1:0] scanOut
);

  logic [L-1:0] ch [N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < N; c++) ch[c] <= '0;
    end else if (scanEn) begin
      for (int c = 0; c < N; c++) ch[c] <= {ch[c][L-2:0], scanIn[c]};
    end else begin
      for (int c = 0; c < N; c++)
        for (int j = 0; j < L; j++)
          ch[c][j] <= ch[c][j] ^ (ch[(c+1)%N][j] & ch[c][(j+1)%L]);
    end
  end

  always_comb
    for (int c = 0; c < N; c++) scanOut[c] = ch[c][L-1];

endmodule

// File: tb/test_reseed_lbist.sv
`timescale 1ns/1ps
module test_reseed_lbist;

  localparam int NC = 4;
  localparam int CL = 8;
  localparam logic [15:0] TAPS = 16'hB400;
  localparam logic [15:0] BASE = 16'hACE1;
  localparam logic [15:0] STEP = 16'h3D1B;
  localparam int A_PATS = 5, A_DEPTH = 4, A_LIVE = 3;
  localparam int B_PATS = 3, B_DEPTH = 2, B_LIVE = 2;

  logic clk = 0;
  logic rstN = 0;
  always #2 clk = ~clk;

  logic startA = 0, startB = 0;
  logic [15:0] goldA = '0, goldB = '0;
  logic [NC-1:0] soA, siA, soB, siB;
  logic seA, doneA, passA, seB, doneB, passB;
  logic [15:0] sigA, sigB;

  int checks = 0;
  int fails = 0;

  reseed_lbist #(.NUM_CHAINS(NC), .CHAIN_LEN(CL), .PATS_PER_SEED(A_PATS),
    .TABLE_DEPTH(A_DEPTH), .ACTIVE_SEEDS(A_LIVE)) i_reseed_lbist (
    .clk(clk), .rstN(rstN), .start(startA), .goldenSig(goldA), .scanOut(soA),
    .scanEn(seA), .scanIn(siA), .done(doneA), .pass(passA), .signature(sigA));
  cut_stub #(.N(NC), .L(CL)) i_cutA (.clk(clk), .rstN(rstN), .scanEn(seA),
    .scanIn(siA), .scanOut(soA));

  reseed_lbist #(.NUM_CHAINS(NC), .CHAIN_LEN(CL), .PATS_PER_SEED(B_PATS),
    .TABLE_DEPTH(B_DEPTH), .ACTIVE_SEEDS(B_LIVE)) i_reseed_lbist_full (
    .clk(clk), .rstN(rstN), .start(startB), .goldenSig(goldB), .scanOut(soB),
    .scanEn(seB), .scanIn(siB), .done(doneB), .pass(passB), .signature(sigB));
  cut_stub #(.N(NC), .L(CL)) i_cutB (.clk(clk), .rstN(rstN), .scanEn(seB),
    .scanIn(siB), .scanOut(soB));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] seedOf(input int i, input int live);
    return (i < live) ? (16'(BASE + 16'(i) * STEP) | 16'h1) : 16'h0;
  endfunction

  function automatic logic [15:0] stepReg(input logic [15:0] r);
    return {r[14:0], ^(r & TAPS)};
  endfunction

  // requirement-level model of a full run against the stand-in core
  function automatic logic [15:0] modelSig(input int live, input int depth, input int pats);
    logic [CL-1:0] cut [NC];
    logic [CL-1:0] nxt [NC];
    logic [15:0] lfsr, misr;
    logic [NC-1:0] outv;
    bit valid;
    misr = '0;
    valid = 0;
    for (int c = 0; c < NC; c++) cut[c] = '0;
    for (int s = 0; s < depth; s++) begin
      if (seedOf(s, live) == 16'h0) break;
      lfsr = seedOf(s, live);
      for (int p = 0; p < pats; p++) begin
        for (int k = 0; k < CL; k++) begin
          for (int c = 0; c < NC; c++) outv[c] = cut[c][CL-1];
          if (valid) misr = stepReg(misr) ^ 16'(outv);
          for (int c = 0; c < NC; c++) cut[c] = {cut[c][CL-2:0], lfsr[c]};
          lfsr = stepReg(lfsr);
        end
        for (int c = 0; c < NC; c++)
          for (int j = 0; j < CL; j++)
            nxt[c][j] = cut[c][j] ^ (cut[(c+1)%NC][j] & cut[c][(j+1)%CL]);
        for (int c = 0; c < NC; c++) cut[c] = nxt[c];
        valid = 1;
      end
    end
    for (int k = 0; k < CL; k++) begin
      for (int c = 0; c < NC; c++) outv[c] = cut[c][CL-1];
      misr = stepReg(misr) ^ 16'(outv);
      for (int c = 0; c < NC; c++) cut[c] = {cut[c][CL-2:0], 1'b0};
    end
    return misr;
  endfunction

  task automatic runTest(input bit useB, input logic [15:0] golden, input int injectAt,
                         input int pats, input logic [15:0] seed0, input logic [15:0] expSig);
    int shifts = 0, caps = 0, cycles = 0, badFlush = 0;
    logic [NC-1:0] firstIn = '0;
    logic se, dn;
    logic [NC-1:0] si;
    if (useB) goldB = golden; else goldA = golden;
    @(negedge clk);
    if (useB) startB = 1; else startA = 1;
    @(negedge clk);
    startA = 0; startB = 0;
    forever begin
      se = useB ? seB : seA;
      dn = useB ? doneB : doneA;
      si = useB ? siB : siA;
      if (dn || cycles > 5000) break;
      if (se) begin
        if (shifts == 0) firstIn = si;
        if (caps == pats && si != '0) badFlush++;
        shifts++;
      end else begin
        caps++;
      end
      if (cycles == injectAt) begin
        if (useB) startB = 1; else startA = 1;
      end else begin
        startA = 0; startB = 0;
      end
      @(negedge clk);
      cycles++;
    end
    startA = 0; startB = 0;
    check("R5 run completes", 32'(useB ? doneB : doneA), 32'd1);
    check("R2 first stimulus slice", 32'(firstIn), 32'(seed0[NC-1:0]));
    check("R4 R5 capture count", 32'(caps), 32'(pats));
    check("R3 R6 shift count", 32'(shifts), 32'(pats * CL + CL));
    check("R6 unload stimulus zero", 32'(badFlush), 32'd0);
    check("R7 R9 signature", 32'(useB ? sigB : sigA), 32'(expSig));
    check("R8 pass", 32'(useB ? passB : passA), 32'(golden == expSig));
  endtask

  initial begin
    logic [15:0] expA, expB, g, held;
    int hold;
    void'($urandom(32'd4242));
    expA = modelSig(A_LIVE, A_DEPTH, A_PATS);
    expB = modelSig(B_LIVE, B_DEPTH, B_PATS);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done low", 32'(doneA), 32'd0);
    check("R1 pass low", 32'(passA), 32'd0);
    check("R1 scanEn low", 32'(seA), 32'd0);
    check("R1 signature zero", 32'(sigA), 32'd0);
    rstN = 1;
    @(negedge clk);
    check("R1 idle after reset", 32'(doneA | seA), 32'd0);

    // directed: matching golden, no stray start; marker ends the table
    runTest(0, expA, -1, A_LIVE * A_PATS, seedOf(0, A_LIVE), expA);

    // R10 done held, signature stable
    held = sigA;
    repeat (17) @(negedge clk);
    check("R10 done held", 32'(doneA), 32'd1);
    check("R10 signature stable", 32'(sigA), 32'(held));

    // directed: start pulse in first shift cycle and mismatching golden
    runTest(0, expA ^ 16'h0100, 0, A_LIVE * A_PATS, seedOf(0, A_LIVE), expA);

    // random runs: random stray start, random golden
    for (int r = 0; r < 6; r++) begin
      g = ($urandom % 2) ? expA : 16'($urandom);
      hold = $urandom % 3;
      repeat (hold) @(negedge clk);
      runTest(0, g, int'($urandom % 130), A_LIVE * A_PATS, seedOf(0, A_LIVE), expA);
      check("R10 done before restart", 32'(doneA), 32'd1);
    end

    // table exhausted without a zero entry
    runTest(1, expB, -1, B_LIVE * B_PATS, seedOf(0, B_LIVE), expB);
    runTest(1, ~expB, 7, B_LIVE * B_PATS, seedOf(0, B_LIVE), expB);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule